// File: doc/BRIEF.md
# Locality Monitor Partial-Tag Array

This block estimates whether a near-memory operation would find its target block in the last-level cache. It holds a tag-only shadow of the cache. The shadow has the cache's associativity and block size and keeps its own least-recently-used order. The shadow changes in two cases. The first is every access the last-level cache reports. The second is every operation the monitor sends to memory-side execution, which is installed as though its block had been brought into the cache. The shadow stores no data and does no coherence work.

Each operation lookup gets a verdict one cycle later. A hit means high locality, and the operation should run on the host side. A miss means low locality, and the operation should run in memory. Only the low bits of each tag are stored. Two blocks whose tags agree in those bits can therefore alias, and aliasing can only turn a miss into a hit. When a cache access and a lookup arrive in the same cycle, the cache access is applied first and the lookup sees its effect.

Each request takes one action, chosen from a small enumeration: none, touch (make a resident way the most recent) or fill (install the tag into the least-recent way). A cache access that hits touches its way. A cache access that misses fills. A lookup that misses fills. A lookup that hits takes no action, because host-side execution reaches the shadow through its own cache access.

Top module: `loc_monitor`

## Requirements
- R1: After reset every way is empty, `res_valid` and `res_high` are 0, and the first lookup of any block returns a miss.
- R2: Address bits [5:0] (block offset) are ignored. Bits [9:6] select one of 16 sets. Bits [17:10] form the stored 8-bit partial tag.
- R3: `res_valid` is 1 exactly in the cycle after a cycle with `op_valid` at 1, and 0 otherwise.
- R4: A cache access installs its block, so a later lookup of that block hits while the block is still among the 16 most recent in its set.
- R5: A lookup that misses installs its block, so a repeated lookup of the same block hits.
- R6: A lookup that hits leaves the replacement order unchanged.
- R7: A cache access that hits a resident block makes it the most recent. The next fill into that set evicts the least-recent block.
- R8: Each set holds 16 distinct blocks at once. Installing a 17th block evicts the block touched longest ago.
- R9: Addresses that differ only above bit 17 alias and give a hit. Addresses that differ within bits [17:10] do not alias.
- R10: When a cache access and a lookup arrive in the same cycle, the cache access is applied first, including any eviction it causes.
- R11: Activity in one set never evicts a block from another set.
- R12: `res_high` is 0 whenever `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| llc_valid | input | 1 | A last-level cache access is reported this cycle |
| llc_addr | input | 32 | Byte address of that cache access |
| op_valid | input | 1 | An operation requests a locality verdict this cycle |
| op_addr | input | 32 | Byte address the operation targets |
| res_valid | output | 1 | Verdict valid, one cycle after the request |
| res_high | output | 1 | 1 = high locality (host side), 0 = low locality (memory side) |

## Verification
The bench builds the monitor with its default parameters: 16 ways, 16 sets, 64-byte blocks and 8-bit partial tags. At 16 ways a full set takes 16 requests, so a bench can fill a set, age it and force an eviction within a few dozen cycles. Sixteen sets let each scenario work in a set of its own, which makes cross-set interference visible. With the tag field ending at bit 17, aliasing can be forced by changing only the upper address bits.

// File: rtl/lm_pkg.sv
package lm_pkg;

    // Action applied to one set of the shadow array by one request.
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_TOUCH = 2'd1,
        ACT_FILL  = 2'd2
    } lm_act_e;

endpackage

// File: rtl/lm_addr_split.sv
module lm_addr_split #(
    parameter int ADDR_W     = 32,
    parameter int BLOCK_BITS = 6,
    parameter int SET_BITS   = 4,
    parameter int PTAG_BITS  = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [SET_BITS-1:0]  set_idx,
    output logic [PTAG_BITS-1:0] ptag
);

    localparam int SET_LO = BLOCK_BITS;
    localparam int TAG_LO = BLOCK_BITS + SET_BITS;

    always_comb begin
        set_idx = addr[SET_LO +: SET_BITS];
        ptag    = addr[TAG_LO +: PTAG_BITS];
    end

endmodule

// File: rtl/lm_set_probe.sv
module lm_set_probe #(
    parameter int WAYS      = 16,
    parameter int PTAG_BITS = 8,
    localparam int WAY_W    = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][PTAG_BITS-1:0] tags,
    input  logic [WAYS-1:0]                vld,
    input  logic [WAYS-1:0][WAY_W-1:0]     ages,
    input  logic [PTAG_BITS-1:0]           ptag,
    output logic                           hit,
    output logic [WAY_W-1:0]               hit_way,
    output logic [WAY_W-1:0]               victim
);

    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic [WAYS-1:0] match;
    logic [WAYS-1:0] is_old;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w]  = vld[w] && (tags[w] == ptag);
        assign is_old[w] = (ages[w] == OLDEST);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        victim  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w])  hit_way = WAY_W'(w);
            if (is_old[w]) victim  = WAY_W'(w);
        end
    end

endmodule

// File: rtl/lm_set_update.sv
module lm_set_update
    import lm_pkg::*;
#(
    parameter int WAYS      = 16,
    parameter int PTAG_BITS = 8,
    localparam int WAY_W    = $clog2(WAYS)
) (
    input  lm_act_e                        act,
    input  logic [WAY_W-1:0]               way,
    input  logic [PTAG_BITS-1:0]           ptag,
    input  logic [WAYS-1:0][PTAG_BITS-1:0] tags_i,
    input  logic [WAYS-1:0]                vld_i,
    input  logic [WAYS-1:0][WAY_W-1:0]     ages_i,
    output logic [WAYS-1:0][PTAG_BITS-1:0] tags_o,
    output logic [WAYS-1:0]                vld_o,
    output logic [WAYS-1:0][WAY_W-1:0]     ages_o
);

    logic [WAYS-1:0][WAY_W-1:0] aged;
    logic [WAY_W-1:0]           ref_age;

    // Promote the chosen way to age 0 and push every younger way back by one.
    always_comb begin
        ref_age = ages_i[way];
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == way)
                aged[w] = '0;
            else if (ages_i[w] < ref_age)
                aged[w] = ages_i[w] + 1'b1;
            else
                aged[w] = ages_i[w];
        end
    end

    always_comb begin
        tags_o = tags_i;
        vld_o  = vld_i;
        ages_o = ages_i;
        unique case (act)
            ACT_NONE: begin
            end
            ACT_TOUCH: begin
                ages_o = aged;
            end
            ACT_FILL: begin
                ages_o      = aged;
                tags_o[way] = ptag;
                vld_o[way]  = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/loc_monitor.sv
module loc_monitor
    import lm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BLOCK_BITS = 6,
    parameter int SET_BITS   = 4,
    parameter int PTAG_BITS  = 8,
    parameter int WAYS       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              llc_valid,
    input  logic [ADDR_W-1:0] llc_addr,
    input  logic              op_valid,
    input  logic [ADDR_W-1:0] op_addr,
    output logic              res_valid,
    output logic              res_high
);

    localparam int SETS  = 1 << SET_BITS;
    localparam int WAY_W = $clog2(WAYS);

    typedef logic [WAYS-1:0][PTAG_BITS-1:0] set_tags_t;
    typedef logic [WAYS-1:0]                set_vld_t;
    typedef logic [WAYS-1:0][WAY_W-1:0]     set_ages_t;

    set_tags_t tag_q [SETS];
    set_vld_t  vld_q [SETS];
    set_ages_t age_q [SETS];

    // ---------------- cache-access path (applied first) ----------------
    logic [SET_BITS-1:0]  l_set;
    logic [PTAG_BITS-1:0] l_ptag;
    logic                 l_hit;
    logic [WAY_W-1:0]     l_hit_way, l_victim, l_way;
    lm_act_e              l_act;
    set_tags_t            l_tags, l_tags_n;
    set_vld_t             l_vld, l_vld_n;
    set_ages_t            l_ages, l_ages_n;

    lm_addr_split #(
        .ADDR_W(ADDR_W), .BLOCK_BITS(BLOCK_BITS),
        .SET_BITS(SET_BITS), .PTAG_BITS(PTAG_BITS)
    ) u_l_split (
        .addr(llc_addr), .set_idx(l_set), .ptag(l_ptag)
    );

    always_comb begin
        l_tags = tag_q[l_set];
        l_vld  = vld_q[l_set];
        l_ages = age_q[l_set];
    end

    lm_set_probe #(.WAYS(WAYS), .PTAG_BITS(PTAG_BITS)) u_l_probe (
        .tags(l_tags), .vld(l_vld), .ages(l_ages), .ptag(l_ptag),
        .hit(l_hit), .hit_way(l_hit_way), .victim(l_victim)
    );

    always_comb begin
        if (!llc_valid)
            l_act = ACT_NONE;
        else if (l_hit)
            l_act = ACT_TOUCH;
        else
            l_act = ACT_FILL;
        l_way = l_hit ? l_hit_way : l_victim;
    end

    lm_set_update #(.WAYS(WAYS), .PTAG_BITS(PTAG_BITS)) u_l_upd (
        .act(l_act), .way(l_way), .ptag(l_ptag),
        .tags_i(l_tags), .vld_i(l_vld), .ages_i(l_ages),
        .tags_o(l_tags_n), .vld_o(l_vld_n), .ages_o(l_ages_n)
    );

    // ---------------- operation lookup path (sees post-access state) ----
    logic [SET_BITS-1:0]  o_set;
    logic [PTAG_BITS-1:0] o_ptag;
    logic                 o_fwd;
    logic                 o_hit;
    logic [WAY_W-1:0]     o_hit_way, o_victim;
    lm_act_e              o_act;
    set_tags_t            o_tags, o_tags_n;
    set_vld_t             o_vld, o_vld_n;
    set_ages_t            o_ages, o_ages_n;

    lm_addr_split #(
        .ADDR_W(ADDR_W), .BLOCK_BITS(BLOCK_BITS),
        .SET_BITS(SET_BITS), .PTAG_BITS(PTAG_BITS)
    ) u_o_split (
        .addr(op_addr), .set_idx(o_set), .ptag(o_ptag)
    );

    always_comb begin
        o_fwd = llc_valid && (l_set == o_set);
        if (o_fwd) begin
            o_tags = l_tags_n;
            o_vld  = l_vld_n;
            o_ages = l_ages_n;
        end else begin
            o_tags = tag_q[o_set];
            o_vld  = vld_q[o_set];
            o_ages = age_q[o_set];
        end
    end

    lm_set_probe #(.WAYS(WAYS), .PTAG_BITS(PTAG_BITS)) u_o_probe (
        .tags(o_tags), .vld(o_vld), .ages(o_ages), .ptag(o_ptag),
        .hit(o_hit), .hit_way(o_hit_way), .victim(o_victim)
    );

    // A hitting lookup leaves the order alone; a missing one is installed.
    always_comb begin
        o_act = (op_valid && !o_hit) ? ACT_FILL : ACT_NONE;
    end

    lm_set_update #(.WAYS(WAYS), .PTAG_BITS(PTAG_BITS)) u_o_upd (
        .act(o_act), .way(o_victim), .ptag(o_ptag),
        .tags_i(o_tags), .vld_i(o_vld), .ages_i(o_ages),
        .tags_o(o_tags_n), .vld_o(o_vld_n), .ages_o(o_ages_n)
    );

    // ---------------- state registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                tag_q[s] <= '0;
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
            end
        end else begin
            if (llc_valid) begin
                tag_q[l_set] <= l_tags_n;
                vld_q[l_set] <= l_vld_n;
                age_q[l_set] <= l_ages_n;
            end
            // Written last: when both target one set, this already holds the access.
            if (op_valid) begin
                tag_q[o_set] <= o_tags_n;
                vld_q[o_set] <= o_vld_n;
                age_q[o_set] <= o_ages_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_high  <= 1'b0;
        end else begin
            res_valid <= op_valid;
            res_high  <= op_valid && o_hit;
        end
    end

endmodule

// File: rtl/lm_checker.sv
module lm_checker #(
    parameter int ADDR_W     = 32,
    parameter int BLOCK_BITS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              llc_valid,
    input logic [ADDR_W-1:0] llc_addr,
    input logic              op_valid,
    input logic [ADDR_W-1:0] op_addr,
    input logic              res_valid,
    input logic              res_high
);

    logic [ADDR_W-BLOCK_BITS-1:0] op_blk, llc_blk;
    assign op_blk  = op_addr[ADDR_W-1:BLOCK_BITS];
    assign llc_blk = llc_addr[ADDR_W-1:BLOCK_BITS];

    p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);

    p_no_verdict_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_high);

    p_repeat_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !llc_valid && $past(op_valid) &&
         (op_blk == $past(op_blk))) |=> res_high);

    p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (llc_valid && op_valid && (llc_blk == op_blk)) |=> res_high);

    p_fill_then_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !llc_valid && $past(llc_valid) &&
         (op_blk == $past(llc_blk))) |=> res_high);

endmodule

bind loc_monitor lm_checker #(
    .ADDR_W(ADDR_W), .BLOCK_BITS(BLOCK_BITS)
) u_lm_checker (.*);

// File: tb/test_loc_monitor.sv
module test_loc_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        llc_valid = 1'b0;
    logic [31:0] llc_addr = '0;
    logic        op_valid = 1'b0;
    logic [31:0] op_addr = '0;
    logic        res_valid;
    logic        res_high;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    loc_monitor #(
        .ADDR_W(32), .BLOCK_BITS(6), .SET_BITS(4), .PTAG_BITS(8), .WAYS(16)
    ) i_loc_monitor (
        .clk(clk), .rst_n(rst_n),
        .llc_valid(llc_valid), .llc_addr(llc_addr),
        .op_valid(op_valid), .op_addr(op_addr),
        .res_valid(res_valid), .res_high(res_high)
    );

    // hi: bits [31:18], ptag: [17:10], set: [9:6], offset: [5:0]
    function automatic logic [31:0] mk(int hi, int ptag, int set, int off);
        logic [31:0] a;
        a = {hi[13:0], ptag[7:0], set[3:0], off[5:0]};
        return a;
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic llc_acc(logic [31:0] a);
        llc_valid = 1'b1; llc_addr = a;
        @(negedge clk);
        llc_valid = 1'b0;
    endtask

    task automatic lookup(logic [31:0] a, string req, logic exp_high);
        op_valid = 1'b1; op_addr = a;
        @(negedge clk);
        op_valid = 1'b0;
        check({req, " valid"}, res_valid, 1'b1);
        check(req, res_high, exp_high);
    endtask

    task automatic both(logic [31:0] la, logic [31:0] oa, string req, logic exp_high);
        llc_valid = 1'b1; llc_addr = la;
        op_valid  = 1'b1; op_addr  = oa;
        @(negedge clk);
        llc_valid = 1'b0; op_valid = 1'b0;
        check({req, " valid"}, res_valid, 1'b1);
        check(req, res_high, exp_high);
    endtask

    task automatic fill_set(int set);
        for (int t = 0; t < 16; t++) llc_acc(mk(0, t, set, 0));
    endtask

    task automatic t_reset;
        check("R1 valid after reset", res_valid, 1'b0);
        check("R12 high after reset", res_high, 1'b0);
        lookup(mk(0, 7, 0, 0), "R1 first lookup miss", 1'b0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        check("R3 idle valid", res_valid, 1'b0);
        check("R12 idle high", res_high, 1'b0);
        lookup(mk(0, 7, 0, 0), "R3 result next cycle", 1'b1);
        @(negedge clk);
        check("R3 valid drops", res_valid, 1'b0);
        check("R12 high drops", res_high, 1'b0);
    endtask

    task automatic t_op_install;
        lookup(mk(0, 33, 1, 4), "R5 first miss", 1'b0);
        lookup(mk(0, 33, 1, 4), "R5 repeat hit", 1'b1);
    endtask

    task automatic t_llc_install;
        llc_acc(mk(0, 44, 2, 0));
        @(negedge clk);
        lookup(mk(0, 44, 2, 8), "R4 after cache access", 1'b1);
        lookup(mk(0, 45, 2, 8), "R4 other block miss", 1'b0);
    endtask

    task automatic t_capacity;
        llc_acc(mk(0, 9, 7, 0));
        fill_set(3);
        for (int t = 0; t < 16; t++) lookup(mk(0, t, 3, 0), "R8 all ways held", 1'b1);
        llc_acc(mk(0, 16, 3, 0));
        lookup(mk(0, 0, 3, 0), "R8 oldest evicted", 1'b0);
        lookup(mk(0, 1, 3, 0), "R8 next oldest evicted by refill", 1'b0);
        lookup(mk(0, 16, 3, 0), "R8 newest kept", 1'b1);
        lookup(mk(0, 9, 7, 0), "R11 other set untouched", 1'b1);
    endtask

    task automatic t_promote;
        fill_set(5);
        llc_acc(mk(0, 0, 5, 0));
        llc_acc(mk(0, 16, 5, 0));
        lookup(mk(0, 0, 5, 0), "R7 promoted block kept", 1'b1);
        lookup(mk(0, 1, 5, 0), "R7 least recent evicted", 1'b0);
    endtask

    task automatic t_hit_no_touch;
        fill_set(6);
        lookup(mk(0, 0, 6, 0), "R6 hit", 1'b1);
        llc_acc(mk(0, 16, 6, 0));
        lookup(mk(0, 0, 6, 0), "R6 hit did not promote", 1'b0);
    endtask

    task automatic t_alias;
        llc_acc(mk(1, 5, 8, 0));
        lookup(mk(2, 5, 8, 0), "R9 upper bits alias", 1'b1);
        lookup(mk(1, 6, 8, 0), "R9 tag bits differ", 1'b0);
    endtask

    task automatic t_mapping;
        llc_acc(mk(0, 3, 9, 0));
        lookup(mk(0, 3, 9, 63), "R2 offset ignored", 1'b1);
        lookup(mk(0, 3, 10, 0), "R2 set bits select", 1'b0);
    endtask

    task automatic t_same_cycle;
        both(mk(0, 2, 11, 0), mk(0, 2, 11, 0), "R10 access then lookup", 1'b1);
        fill_set(12);
        both(mk(0, 16, 12, 0), mk(0, 0, 12, 0), "R10 eviction seen first", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timing();
        t_op_install();
        t_llc_install();
        t_capacity();
        t_promote();
        t_hit_no_touch();
        t_alias();
        t_mapping();
        t_same_cycle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule